// File: doc/BRIEF.md
# Multi-Key-Length AES Encryption Core

This block is an iterative AES forward cipher. It turns one 128-bit plaintext block into one 128-bit ciphertext block. A single round datapath is reused for every round. The round keys are derived from the stored cipher key while the block is in flight, so no expanded-key table is kept. The key can be 128, 192 or 256 bits long. The data block is always 128 bits.

Each round takes three clock cycles:

- byte substitution together with row rotation,
- column mixing,
- round-key addition.

The final round leaves out the column mixing but still takes all three cycles. Two more cycles are added per block: one for the initial key whitening and one for registering the result. A block therefore occupies 2 + 3 × rounds cycles, which is 32, 38 or 44 cycles.

A caller loads the key once with a length code. It then offers blocks through a valid/ready input. There is no start command: a block begins as soon as a key is present and the engine is free. While one block is being ciphered, one further block can wait in a holding register. This lets back-to-back blocks leave at the full rate.

Top module: `aes_enc_core`

## Requirements
- R1: Blocks and keys are big-endian, with byte 0 in the most significant bits. A key sits left-aligned in `key_in`: a 128-bit key in bits 255:128, a 192-bit key in bits 255:64. `out_data` carries the standard AES forward-cipher result for the loaded key and the input block.
- R2: When the engine is idle and a key is loaded, `out_valid` is first high 3 × rounds + 1 clock edges after the edge that accepts the block. That is 31, 37 or 43 edges, so each block spans 2 + 3 × rounds cycles. The round count is 10, 12 or 14 for `key_len` 0, 1 or 2.
- R3: A block offered before any key has been loaded is held and produces no output. Once a key is loaded, the block starts on the next edge, and `out_valid` is first high 3 × rounds + 2 edges after the key-load edge.
- R4: After reset, `in_ready` is 1 and `out_valid` is 0.
- R5: While a block is in progress, one more block is accepted into the holding register. `in_ready` then stays 0 until that held block moves into the engine. `in_ready` returns on the next cycle, so the block after it is accepted exactly 2 + 3 × rounds + 1 edges after the first block.
- R6: When the holding register is kept full, consecutive `out_valid` pulses are exactly 2 + 3 × rounds cycles apart.
- R7: `out_valid` is high for exactly one cycle per block. `out_data` keeps its value after the pulse.
- R8: A key load takes effect for blocks that start after it. A block already running finishes with the key it started with. A block that starts on the same edge as a key load uses the key held before that edge.
- R9: `key_len` code 3 behaves the same as code 2, giving a 256-bit key with 14 rounds.
- R10: Results leave in the order the blocks were accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_load | input | 1 | Captures `key_in` and `key_len` on this edge |
| key_len | input | 2 | Key length code: 0 = 128, 1 = 192, 2 or 3 = 256 bits |
| key_in | input | 256 | Cipher key, left-aligned |
| in_valid | input | 1 | Input block offered |
| in_ready | output | 1 | Engine or holding register can take a block |
| in_data | input | 128 | Plaintext block |
| out_valid | output | 1 | One-cycle result strobe |
| out_data | output | 128 | Ciphertext block |

## Verification
Two events can land on the same clock edge: a key load and the start of a block. The bench drives `key_load` together with a block offered to an idle engine, so that the key register is written on the same edge that a new block captures it. The first result must match the previous key, with the 128-bit latency. The block that follows must match the newly loaded 256-bit key. A second case loads a new key while a block is in mid-flight and a second block waits in the holding register. That case checks that the running block is unchanged and keeps its round count and timing, and that the held block picks up the new key.

// File: rtl/aes_enc_core.sv
`timescale 1ns/1ps
module aes_enc_core (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         key_load,
  input  logic [1:0]   key_len,
  input  logic [255:0] key_in,
  input  logic         in_valid,
  output logic         in_ready,
  input  logic [127:0] in_data,
  output logic         out_valid,
  output logic [127:0] out_data
);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_OUT} state_t;

  function automatic logic [7:0] xt(input logic [7:0] a);
    return {a[6:0], 1'b0} ^ (a[7] ? 8'h1b : 8'h00);
  endfunction

  function automatic logic [7:0] gmul(input logic [7:0] a, input logic [7:0] b);
    logic [7:0] p, q;
    p = '0;
    q = a;
    for (int i = 0; i < 8; i++) begin
      if (b[i]) p = p ^ q;
      q = xt(q);
    end
    return p;
  endfunction

  function automatic logic [7:0] rl(input logic [7:0] b, input int n);
    return (b << n) | (b >> (8 - n));
  endfunction

  function automatic logic [7:0] sbox(input logic [7:0] x);
    logic [7:0] s, v;
    s = x;
    v = 8'h01;
    for (int i = 1; i < 8; i++) begin
      s = gmul(s, s);
      v = gmul(v, s);
    end
    return v ^ rl(v, 1) ^ rl(v, 2) ^ rl(v, 3) ^ rl(v, 4) ^ 8'h63;
  endfunction

  function automatic logic [31:0] sub_word(input logic [31:0] w);
    return {sbox(w[31:24]), sbox(w[23:16]), sbox(w[15:8]), sbox(w[7:0])};
  endfunction

  function automatic logic [127:0] sub_shift(input logic [127:0] s);
    logic [127:0] o;
    for (int c = 0; c < 4; c++)
      for (int r = 0; r < 4; r++)
        o[127 - 8*(4*c + r) -: 8] = sbox(s[127 - 8*(4*((c + r) % 4) + r) -: 8]);
    return o;
  endfunction

  function automatic logic [127:0] mix(input logic [127:0] s);
    logic [127:0] o;
    logic [7:0] a0, a1, a2, a3;
    for (int c = 0; c < 4; c++) begin
      a0 = s[127 - 32*c -: 8];
      a1 = s[119 - 32*c -: 8];
      a2 = s[111 - 32*c -: 8];
      a3 = s[103 - 32*c -: 8];
      o[127 - 32*c -: 32] = {xt(a0) ^ xt(a1) ^ a1 ^ a2 ^ a3,
                             a0 ^ xt(a1) ^ xt(a2) ^ a2 ^ a3,
                             a0 ^ a1 ^ xt(a2) ^ xt(a3) ^ a3,
                             xt(a0) ^ a0 ^ a1 ^ a2 ^ xt(a3)};
    end
    return o;
  endfunction

  state_t       state;
  logic [255:0] key_q;
  logic [1:0]   len_q;
  logic         key_vld;
  logic [127:0] hold_q;
  logic         hold_vld;
  logic [127:0] blk;
  logic [1:0]   phase;
  logic [3:0]   rnd;
  logic [1:0]   act_len;
  logic [255:0] kw;
  logic [3:0]   kpos;
  logic [7:0]   rcon;

  logic [3:0]   nk, nr;
  logic         last, kwrap, accept, start;
  logic [127:0] src;
  logic [31:0]  kt, kf, n1, n2;
  logic [255:0] kw_nx;

  assign nk       = (act_len == 2'd0) ? 4'd4  : (act_len == 2'd1) ? 4'd6  : 4'd8;
  assign nr       = (act_len == 2'd0) ? 4'd10 : (act_len == 2'd1) ? 4'd12 : 4'd14;
  assign last     = (rnd == nr);
  assign kwrap    = (kpos + 4'd2 == nk);
  assign in_ready = !hold_vld;
  assign accept   = in_valid && in_ready;
  assign start    = (state == S_IDLE) && key_vld && (hold_vld || in_valid);
  assign src      = hold_vld ? hold_q : in_data;

  always_comb begin
    case (act_len)
      2'd0:    kt = kw[159:128];
      2'd1:    kt = kw[95:64];
      default: kt = kw[31:0];
    endcase
    if (kpos == 4'd0)
      kf = sub_word({kt[23:0], kt[31:24]}) ^ {rcon, 24'h0};
    else if (act_len == 2'd2 && kpos == 4'd4)
      kf = sub_word(kt);
    else
      kf = kt;
    n1 = kw[255:224] ^ kf;
    n2 = kw[223:192] ^ n1;
    case (act_len)
      2'd0:    kw_nx = {kw[191:128], n1, n2, 128'h0};
      2'd1:    kw_nx = {kw[191:64], n1, n2, 64'h0};
      default: kw_nx = {kw[191:0], n1, n2};
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      key_q     <= '0;
      len_q     <= '0;
      key_vld   <= 1'b0;
      hold_q    <= '0;
      hold_vld  <= 1'b0;
      blk       <= '0;
      phase     <= '0;
      rnd       <= '0;
      act_len   <= '0;
      kw        <= '0;
      kpos      <= '0;
      rcon      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= 1'b0;
      if (key_load) begin
        key_q   <= key_in;
        len_q   <= (key_len == 2'd3) ? 2'd2 : key_len;
        key_vld <= 1'b1;
      end
      if (accept && !start) begin
        hold_q   <= in_data;
        hold_vld <= 1'b1;
      end else if (start && hold_vld) begin
        hold_vld <= 1'b0;
      end
      case (state)
        S_IDLE: if (start) begin
          blk     <= src ^ key_q[255:128];
          kw      <= key_q;
          act_len <= len_q;
          kpos    <= '0;
          rcon    <= 8'h01;
          phase   <= 2'd0;
          rnd     <= 4'd1;
          state   <= S_RUN;
        end
        S_RUN: begin
          if (phase != 2'd2) begin
            kw   <= kw_nx;
            kpos <= kwrap ? 4'd0 : kpos + 4'd2;
            if (kwrap) rcon <= xt(rcon);
          end
          case (phase)
            2'd0: begin
              blk   <= sub_shift(blk);
              phase <= 2'd1;
            end
            2'd1: begin
              if (!last) blk <= mix(blk);
              phase <= 2'd2;
            end
            default: begin
              blk   <= blk ^ kw[255:128];
              phase <= 2'd0;
              if (last) state <= S_OUT;
              else      rnd   <= rnd + 4'd1;
            end
          endcase
        end
        default: begin
          out_data  <= blk;
          out_valid <= 1'b1;
          state     <= S_IDLE;
        end
      endcase
    end
  end

endmodule

// File: rtl/aes_enc_chk.sv
`timescale 1ns/1ps
module aes_enc_chk (
  input logic clk,
  input logic rst_n,
  input logic key_load,
  input logic in_valid,
  input logic in_ready,
  input logic out_valid
);

  logic [1:0] pending;
  logic       key_seen;
  logic       had_out;
  logic [7:0] gap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pending  <= '0;
      key_seen <= 1'b0;
      had_out  <= 1'b0;
      gap      <= '0;
    end else begin
      pending <= pending + {1'b0, (in_valid && in_ready)} - {1'b0, out_valid};
      if (key_load) key_seen <= 1'b1;
      if (out_valid) begin
        had_out <= 1'b1;
        gap     <= '0;
      end else if (gap != 8'hff) begin
        gap <= gap + 8'd1;
      end
    end
  end

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R5
  hold_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == 2'd2) |-> !in_ready);

  // R5
  pending_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pending != 2'd3);

  // R4
  empty_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pending == 2'd0) |-> in_ready);

  // R3
  key_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> key_seen);

  // R6
  out_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && had_out) |-> (gap >= 8'd31));

endmodule

bind aes_enc_core aes_enc_chk i_aes_enc_chk (
  .clk(clk), .rst_n(rst_n), .key_load(key_load),
  .in_valid(in_valid), .in_ready(in_ready), .out_valid(out_valid)
);

// File: tb/test_aes_enc_core.sv
`timescale 1ns/1ps
module test_aes_enc_core;

  localparam logic [127:0] K128 = 128'h000102030405060708090a0b0c0d0e0f;
  localparam logic [191:0] K192 = 192'h000102030405060708090a0b0c0d0e0f1011121314151617;
  localparam logic [255:0] K256 = 256'h000102030405060708090a0b0c0d0e0f101112131415161718191a1b1c1d1e1f;
  localparam logic [127:0] PT   = 128'h00112233445566778899aabbccddeeff;
  localparam logic [127:0] C128 = 128'h69c4e0d86a7b0430d8cdb78070b4c55a;
  localparam logic [127:0] C192 = 128'hdda97ca4864cdfe06eaf70a0ec0d7191;
  localparam logic [127:0] C256 = 128'h8ea2b7ca516745bfeafc49904b496089;
  localparam logic [127:0] KB   = 128'h2b7e151628aed2a6abf7158809cf4f3c;
  localparam logic [127:0] PB   = 128'h3243f6a8885a308d313198a2e0370734;
  localparam logic [127:0] CB   = 128'h3925841d02dc09fbdc118597196a0b32;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         key_load = 1'b0;
  logic [1:0]   key_len = '0;
  logic [255:0] key_in = '0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [127:0] in_data = '0;
  logic         out_valid;
  logic [127:0] out_data;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  int nout = 0;
  int nexp = 0;
  logic [127:0] log_d [64];
  int           log_c [64];

  aes_enc_core i_aes_enc_core (
    .clk(clk), .rst_n(rst_n), .key_load(key_load), .key_len(key_len),
    .key_in(key_in), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .out_valid(out_valid), .out_data(out_data)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) if (out_valid && nout < 64) begin
    log_d[nout] = out_data;
    log_c[nout] = cyc;
    nout++;
  end

  task automatic check(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_key(input logic [255:0] k, input logic [1:0] l, output int kc);
    key_in = k; key_len = l; key_load = 1'b1;
    kc = cyc + 1;
    @(negedge clk);
    key_load = 1'b0;
  endtask

  task automatic send(input logic [127:0] d, output int ac);
    in_data = d; in_valid = 1'b1;
    while (!in_ready) @(negedge clk);
    ac = cyc + 1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic get_out(output logic [127:0] d, output int oc);
    wait (nout > nexp);
    d = log_d[nexp];
    oc = log_c[nexp];
    nexp++;
    @(negedge clk);
    check(!out_valid && out_data == d, "R7 pulse/hold", {127'h0, out_valid}, 128'h0);
  endtask

  task automatic t_reset;
    check(in_ready == 1'b1, "R4 in_ready after reset", {127'h0, in_ready}, 128'h1);
    check(out_valid == 1'b0, "R4 out_valid after reset", {127'h0, out_valid}, 128'h0);
  endtask

  task automatic t_no_key;
    int ac, kc, oc;
    logic [127:0] d;
    send(PT, ac);
    check(in_ready == 1'b0, "R3 block parked without key", {127'h0, in_ready}, 128'h0);
    repeat (40) @(negedge clk);
    check(nout == 0, "R3 no output without key", 128'(nout), 128'h0);
    load_key({K128, 128'h0}, 2'd0, kc);
    get_out(d, oc);
    check(d == C128, "R1 128-bit vector after late key", d, C128);
    check(oc - kc == 32, "R3 start after key load", 128'(oc - kc), 128'd32);
  endtask

  task automatic t_vec(input logic [255:0] k, input logic [1:0] l, input logic [127:0] p,
                       input logic [127:0] exp, input int nr, input string req);
    int ac, kc, oc;
    logic [127:0] d;
    load_key(k, l, kc);
    send(p, ac);
    get_out(d, oc);
    check(d == exp, req, d, exp);
    check(oc - ac == 3*nr + 1, "R2 latency", 128'(oc - ac), 128'(3*nr + 1));
  endtask

  task automatic t_stream;
    int kc, a0, a1, a2, o0, o1, o2;
    logic [127:0] d0, d1, d2;
    load_key({K192, 64'h0}, 2'd1, kc);
    send(PT, a0);
    send(PT, a1);
    check(in_ready == 1'b0, "R5 ready low with held block", {127'h0, in_ready}, 128'h0);
    send(PT, a2);
    check(a2 - a0 == 39, "R5 ready returns after hand-over", 128'(a2 - a0), 128'd39);
    get_out(d0, o0);
    get_out(d1, o1);
    get_out(d2, o2);
    check(o0 - a0 == 37, "R2 first of stream", 128'(o0 - a0), 128'd37);
    check(o1 - o0 == 38, "R6 spacing 1", 128'(o1 - o0), 128'd38);
    check(o2 - o1 == 38, "R6 spacing 2", 128'(o2 - o1), 128'd38);
    check(d0 == C192 && d1 == C192 && d2 == C192, "R1 stream data", d2, C192);
  endtask

  task automatic t_key_swap;
    int kc, a0, a1, o0, o1;
    logic [127:0] d0, d1;
    load_key({K128, 128'h0}, 2'd0, kc);
    send(PT, a0);
    repeat (5) @(negedge clk);
    load_key(K256, 2'd2, kc);
    send(PT, a1);
    get_out(d0, o0);
    get_out(d1, o1);
    check(d0 == C128, "R8 running block keeps key", d0, C128);
    check(o0 - a0 == 31, "R8 running block keeps rounds", 128'(o0 - a0), 128'd31);
    check(d1 == C256, "R10 second block uses new key in order", d1, C256);
    check(o1 - o0 == 44, "R6 held block spacing", 128'(o1 - o0), 128'd44);
  endtask

  task automatic t_same_cycle;
    int kc, ac, oc;
    logic [127:0] d;
    load_key({K128, 128'h0}, 2'd0, kc);
    check(in_ready == 1'b1, "R8 idle before same-edge case", {127'h0, in_ready}, 128'h1);
    key_in = K256; key_len = 2'd2; key_load = 1'b1;
    in_data = PT; in_valid = 1'b1;
    ac = cyc + 1;
    @(negedge clk);
    key_load = 1'b0; in_valid = 1'b0;
    get_out(d, oc);
    check(d == C128, "R8 same-edge start uses old key", d, C128);
    check(oc - ac == 31, "R8 same-edge latency", 128'(oc - ac), 128'd31);
    send(PT, ac);
    get_out(d, oc);
    check(d == C256, "R8 next block uses new key", d, C256);
    check(oc - ac == 43, "R2 256-bit latency", 128'(oc - ac), 128'd43);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_no_key;
    t_vec({KB, 128'h0}, 2'd0, PB, CB, 10, "R1 128-bit second vector");
    t_vec({K192, 64'h0}, 2'd1, PT, C192, 12, "R1 192-bit vector");
    t_vec(K256, 2'd2, PT, C256, 14, "R1 256-bit vector");
    t_vec(K256, 2'd3, PT, C256, 14, "R9 code 3 as 256-bit");
    t_stream;
    t_key_swap;
    t_same_cycle;
    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R2 watchdog: actual=hung expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule